// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block receives a stream of command bytes from a byte-wide host link and turns them into accesses on a small register file. Each byte splits into two nibbles. The upper nibble selects an operation and the lower nibble carries four bits of payload. A register address and a write byte are each built from two separate nibble commands, one for the low half and one for the high half. A write is committed when the high data nibble arrives. Reads return one byte each on a valid/ready response stream.

A host can chain many transactions into one command stream. For example, it can read the identification register, write a test pattern to the scratch register and read it back, and then do the same with a second pattern. It collects one response byte per read, in order. A read may also advance the address afterwards. That advance counts only in the low address nibble, so a burst of incrementing reads stays inside one page of 16 registers.

The register file holds three kinds of register. The first is a read-only identification register holding a constant. The second is a scratch register. The third is a parameterised bank of general registers. All other addresses read as zero.

Top module: `nibble_reg_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0, `cmd_ready` is 1, the address register is 0x00 and the latched low data nibble is 0x0.
- R2: Opcode 0x1 (command byte bits 7:4) loads address bits 3:0 from the payload (bits 3:0). Opcode 0x2 loads address bits 7:4. Neither changes the other half of the address.
- R3: Opcode 0x3 latches the payload as the low data nibble. Opcode 0x4 writes the byte {payload, latched low nibble} to the register at the current address.
- R4: Opcode 0x5 produces exactly one response byte, equal to the content of the register at the current address when the command is accepted. The address is left unchanged.
- R5: Opcode 0x6 reads like opcode 0x5 and then adds one to address bits 3:0. The count wraps from 0xF to 0x0, and address bits 7:4 are never changed by it.
- R6: The identification register at `ID_ADDR` (default 0x00) always reads `ID_VALUE` (default 0xA5). Writes to it have no effect.
- R7: The scratch register at `SCRATCH_ADDR` (default 0x01) reads back the last byte written to it.
- R8: `NUM_GP` general registers (default 16) start at `GP_BASE` (default 0x10) and read back what was last written to them. Every other address reads 0x00 and ignores writes.
- R9: Opcodes 0x0 and 0x7 through 0xF are accepted without changing the address, the latched data nibble, any register or the response stream.
- R10: While a response byte is pending, `cmd_ready` is 0. `rsp_byte` and `rsp_valid` hold steady until `rsp_ready` is seen high.
- R11: Opcode 0x4 leaves the address and the latched low nibble unchanged. Repeated data pairs therefore all go to the same register, and the last one wins. A lone opcode 0x4 reuses the previous low nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_byte | input | CMD_W | Command: opcode in upper nibble, payload in lower |
| cmd_ready | output | 1 | Command accepted on this edge when high with `cmd_valid` |
| rsp_valid | output | 1 | Response byte pending |
| rsp_byte | output | CMD_W | Response byte |
| rsp_ready | input | 1 | Host takes the response byte |

## Verification
The bench writes a distinct value to all 256 addresses and then reads every address back. This catches a bad address decode: a decoder that aliases the general bank, lets the identification register be overwritten, or writes to unmapped addresses would read back wrong bytes. Incrementing reads are driven across both page ends, 0x1F to 0x10 and 0x0F to 0x00. A design that carried into the high nibble would return the wrong register's value. Reserved opcodes are placed between a low nibble latch and a data commit, so a decoder that let them touch state would commit a different byte. The bench also holds back `rsp_ready`. A response path that dropped or changed a byte, or took new commands while one was pending, would then show it.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
   localparam logic [3:0] OP_ADDR_LO  = 4'h1;
   localparam logic [3:0] OP_ADDR_HI  = 4'h2;
   localparam logic [3:0] OP_DATA_LO  = 4'h3;
   localparam logic [3:0] OP_DATA_WR  = 4'h4;
   localparam logic [3:0] OP_READ     = 4'h5;
   localparam logic [3:0] OP_READ_INC = 4'h6;
endpackage

// File: rtl/nrd_cmd_decode.sv
module nrd_cmd_decode #(
   parameter int CMD_W = 8,
   localparam int NIB_W = CMD_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_fire,
   input  logic [CMD_W-1:0] cmd_byte,
   output logic [CMD_W-1:0] addr_q,
   output logic             wr_en,
   output logic [CMD_W-1:0] wr_data,
   output logic             rd_push
);
   import nrd_pkg::*;

   logic [NIB_W-1:0] op;
   logic [NIB_W-1:0] pay;
   logic [NIB_W-1:0] dlo_q;
   logic             known_op;

   assign op  = cmd_byte[CMD_W-1:NIB_W];
   assign pay = cmd_byte[NIB_W-1:0];

   always_comb begin
      known_op = (op == OP_ADDR_LO) || (op == OP_ADDR_HI) || (op == OP_DATA_LO) ||
                 (op == OP_DATA_WR) || (op == OP_READ) || (op == OP_READ_INC);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         dlo_q  <= '0;
      end else if (cmd_fire) begin
         case (op)
            OP_ADDR_LO:  addr_q[NIB_W-1:0]     <= pay;
            OP_ADDR_HI:  addr_q[CMD_W-1:NIB_W] <= pay;
            OP_DATA_LO:  dlo_q                 <= pay;
            OP_READ_INC: addr_q[NIB_W-1:0]     <= addr_q[NIB_W-1:0] + 1'b1;
            default: ;
         endcase
      end
   end

   assign wr_en   = cmd_fire && (op == OP_DATA_WR);
   assign wr_data = {pay, dlo_q};
   assign rd_push = cmd_fire && ((op == OP_READ) || (op == OP_READ_INC));

   AST_INC_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && op == OP_READ_INC) |=>
         (addr_q[CMD_W-1:NIB_W] == $past(addr_q[CMD_W-1:NIB_W])) &&
         (addr_q[NIB_W-1:0] == $past(addr_q[NIB_W-1:0]) + 1'b1)); // R5
   AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && !known_op) |=> ($stable(addr_q) && $stable(dlo_q))); // R9
   AST_WRITE_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && op == OP_DATA_WR) |=> ($stable(addr_q) && $stable(dlo_q))); // R11
endmodule

// File: rtl/nrd_regfile.sv
module nrd_regfile #(
   parameter int          DW           = 8,
   parameter int          ID_ADDR      = 0,
   parameter int          SCRATCH_ADDR = 1,
   parameter logic [7:0]  ID_VALUE     = 8'hA5,
   parameter int          GP_BASE      = 16,
   parameter int          NUM_GP       = 16,
   localparam int GP_IW = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] addr,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam logic [DW-1:0] ID_A  = DW'(ID_ADDR);
   localparam logic [DW-1:0] SCR_A = DW'(SCRATCH_ADDR);
   localparam logic [DW:0]   GP_LO = (DW+1)'(GP_BASE);
   localparam logic [DW:0]   GP_HI = (DW+1)'(GP_BASE + NUM_GP);

   logic [DW-1:0] scratch_q;
   logic          gp_hit;
   logic [DW-1:0] gp_rd;
   logic          is_id;
   logic          is_scr;

   assign is_id  = (addr == ID_A);
   assign is_scr = (addr == SCR_A);

   always_ff @(posedge clk) begin
      if (!rst_n)
         scratch_q <= '0;
      else if (we && is_scr)
         scratch_q <= wdata;
   end

   generate
      if (NUM_GP > 0) begin : g_bank
         logic [DW-1:0] off;
         logic [DW-1:0] rd_arr [NUM_GP];
         assign off    = addr - GP_LO[DW-1:0];
         assign gp_hit = ({1'b0, addr} >= GP_LO) && ({1'b0, addr} < GP_HI);
         for (genvar i = 0; i < NUM_GP; i++) begin : g_reg
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  q <= '0;
               else if (we && gp_hit && (off[GP_IW-1:0] == GP_IW'(i)))
                  q <= wdata;
            end
            assign rd_arr[i] = q;
         end
         assign gp_rd = rd_arr[off[GP_IW-1:0]];
      end else begin : g_nobank
         assign gp_hit = 1'b0;
         assign gp_rd  = '0;
      end
   endgenerate

   always_comb begin
      if (is_id)       rdata = ID_VALUE[DW-1:0];
      else if (is_scr) rdata = scratch_q;
      else if (gp_hit) rdata = gp_rd;
      else             rdata = '0;
   end

   AST_SCRATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && is_scr) |=> $stable(scratch_q)); // R7
   AST_SCRATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && is_scr) |=> (scratch_q == $past(wdata))); // R7
endmodule

// File: rtl/nrd_rsp_out.sv
module nrd_rsp_out #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          rsp_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_byte
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_byte  <= '0;
      end else if (push) begin
         rsp_valid <= 1'b1;
         rsp_byte  <= push_data;
      end else if (rsp_valid && rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte))); // R10
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !rsp_valid); // R10
   AST_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> rsp_valid); // R4
endmodule

// File: rtl/nibble_reg_decoder.sv
module nibble_reg_decoder #(
   parameter int         CMD_W        = 8,
   parameter int         ID_ADDR      = 0,
   parameter int         SCRATCH_ADDR = 1,
   parameter logic [7:0] ID_VALUE     = 8'hA5,
   parameter int         GP_BASE      = 16,
   parameter int         NUM_GP       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_byte,
   output logic             cmd_ready,
   output logic             rsp_valid,
   output logic [CMD_W-1:0] rsp_byte,
   input  logic             rsp_ready
);
   localparam int ADDR_SPAN = 1 << CMD_W;

   generate
      if (CMD_W != 8) begin : g_bad_width
         $error("CMD_W must be 8: two 4-bit nibbles per command");
      end
      if (ID_ADDR == SCRATCH_ADDR) begin : g_bad_map
         $error("ID and scratch addresses must differ");
      end
      if (GP_BASE + NUM_GP > ADDR_SPAN) begin : g_bad_bank
         $error("general register bank exceeds address space");
      end
      if (NUM_GP > 0 && ((ID_ADDR >= GP_BASE && ID_ADDR < GP_BASE + NUM_GP) ||
          (SCRATCH_ADDR >= GP_BASE && SCRATCH_ADDR < GP_BASE + NUM_GP))) begin : g_overlap
         $error("general bank overlaps ID or scratch address");
      end
   endgenerate

   logic             cmd_fire;
   logic [CMD_W-1:0] addr_q;
   logic             wr_en;
   logic [CMD_W-1:0] wr_data;
   logic             rd_push;
   logic [CMD_W-1:0] rd_data;

   assign cmd_ready = !rsp_valid;
   assign cmd_fire  = cmd_valid && cmd_ready;

   nrd_cmd_decode #(.CMD_W(CMD_W)) dec_i (
      .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_byte(cmd_byte),
      .addr_q(addr_q), .wr_en(wr_en), .wr_data(wr_data), .rd_push(rd_push));

   nrd_regfile #(
      .DW(CMD_W), .ID_ADDR(ID_ADDR), .SCRATCH_ADDR(SCRATCH_ADDR),
      .ID_VALUE(ID_VALUE), .GP_BASE(GP_BASE), .NUM_GP(NUM_GP)
   ) rf_i (
      .clk(clk), .rst_n(rst_n), .addr(addr_q), .we(wr_en),
      .wdata(wr_data), .rdata(rd_data));

   nrd_rsp_out #(.DW(CMD_W)) rsp_i (
      .clk(clk), .rst_n(rst_n), .push(rd_push), .push_data(rd_data),
      .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte));

   AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> !cmd_ready); // R10
   AST_READ_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_push |=> (rsp_byte == $past(rd_data))); // R4
endmodule

// File: tb/nibble_reg_decoder_tb_top.sv
module nibble_reg_decoder_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       cmd_ready;
   logic       rsp_valid;
   logic [7:0] rsp_byte;
   logic       rsp_ready = 1'b0;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [256];

   always #2 clk = ~clk;

   nibble_reg_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
      .rsp_ready(rsp_ready));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = b;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic set_addr(input logic [7:0] a);
      send({4'h1, a[3:0]});
      send({4'h2, a[7:4]});
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] v);
      set_addr(a);
      send({4'h3, v[3:0]});
      send({4'h4, v[7:4]});
   endtask

   task automatic rd(input logic inc, output logic [7:0] got);
      send(inc ? 8'h60 : 8'h50);
      chk("R4 response valid", {7'b0, rsp_valid}, 8'h01);
      got = rsp_byte;
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R4 single response", {7'b0, rsp_valid}, 8'h00);
   endtask

   function automatic logic [7:0] expect_wr(input logic [7:0] a, input logic [7:0] old,
                                            input logic [7:0] v);
      if (a == 8'h00) return 8'hA5;
      if (a == 8'h01) return v;
      if (a >= 8'h10 && a <= 8'h1F) return v;
      return old;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] got;
      logic [7:0] st;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      model[0] = 8'hA5;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset rsp_valid", {7'b0, rsp_valid}, 8'h00);
      chk("R1 reset cmd_ready", {7'b0, cmd_ready}, 8'h01);
      rd(1'b0, got);
      chk("R1 address resets to ID", got, 8'hA5);
      // R1: low nibble resets to 0
      send(8'h11);
      send(8'h47);
      rd(1'b0, got);
      chk("R1 low nibble reset", got, 8'h70);
      model[1] = 8'h70;

      // R3 R6 R7 R8: full sweep write then readback
      for (int a = 0; a < 256; a++) begin
         logic [7:0] v;
         v = 8'((a * 7 + 3) ^ 8'h5A);
         wr(8'(a), v);
         model[a] = expect_wr(8'(a), model[a], v);
      end
      for (int a = 0; a < 256; a++) begin
         set_addr(8'(a));
         rd(1'b0, got);
         chk($sformatf("R8 R6 R2 readback addr %02h", a), got, model[a]);
      end

      // R6: ID write ignored
      wr(8'h00, 8'hFF);
      rd(1'b0, got);
      chk("R6 ID write ignored", got, 8'hA5);

      // chained: ID read, scratch 55/AA readback (R7)
      set_addr(8'h00);
      rd(1'b0, got);
      chk("R7 chain ID", got, 8'hA5);
      wr(8'h01, 8'h55);
      rd(1'b0, got);
      chk("R7 scratch 55", got, 8'h55);
      wr(8'h01, 8'hAA);
      rd(1'b0, got);
      chk("R7 scratch AA", got, 8'hAA);

      // R5: wrap 0x1F -> 0x10
      set_addr(8'h1E);
      rd(1'b1, got); chk("R5 inc 1E", got, model[8'h1E]);
      rd(1'b1, got); chk("R5 inc 1F", got, model[8'h1F]);
      rd(1'b1, got); chk("R5 wrap to 10", got, model[8'h10]);
      rd(1'b0, got); chk("R5 now at 11", got, model[8'h11]);
      // R5: wrap 0x0F -> 0x00
      set_addr(8'h0F);
      rd(1'b1, got); chk("R5 inc 0F", got, 8'h00);
      rd(1'b0, got); chk("R5 wrap to 00 not 10", got, 8'hA5);

      // R2: address halves independent
      set_addr(8'h13);
      send(8'h21);
      rd(1'b0, got); chk("R2 high nibble only", got, model[8'h13]);
      send(8'h1A);
      rd(1'b0, got); chk("R2 low nibble only", got, model[8'h1A]);

      // R9 R11: reserved opcodes between latch and commit
      set_addr(8'h01);
      send(8'h33);
      for (int op = 7; op < 16; op++) send({4'(op), 4'hE});
      send(8'h0E);
      chk("R9 no response from reserved", {7'b0, rsp_valid}, 8'h00);
      send(8'h46);
      rd(1'b0, got); chk("R9 reserved inert", got, 8'h63);
      send(8'h49);
      rd(1'b0, got); chk("R11 low nibble reused", got, 8'h93);

      // R11: multi-byte write lands at one address
      set_addr(8'h12);
      for (int k = 1; k <= 32; k++) begin
         send({4'h3, 4'(k)});
         send({4'h4, 4'(k >> 4)});
      end
      rd(1'b0, got); chk("R11 last of 32 wins", got, 8'h20);
      set_addr(8'h13);
      rd(1'b0, got); chk("R11 neighbour untouched", got, model[8'h13]);

      // R10: stall with rsp_ready low
      set_addr(8'h01);
      send(8'h50);
      st = rsp_byte;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk("R10 valid held", {7'b0, rsp_valid}, 8'h01);
         chk("R10 cmd stalled", {7'b0, cmd_ready}, 8'h00);
         chk("R10 byte stable", rsp_byte, st);
      end
      chk("R10 stalled byte value", st, 8'h93);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R10 released", {7'b0, cmd_ready}, 8'h01);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule